// File: doc/BRIEF.md
# Pseudo-Noise Multichip Sync Engine

This block lines up several identical devices on one shared clock edge. One device is set as the master: it runs a small linear-feedback generator and sends a continuously repeating 15-chip pseudo-noise code out on a serial sync line. Board wiring returns that line to the sync input of every device, the master included. Each device keeps the last 15 received chips in a correlator. When they exactly equal the expected code, the device emits a single-cycle sync pulse.

The sync pulse restarts the device's clock-divider counter and its oscillator phase accumulator. Every device whose pulse comes from the same received code therefore ends up with the same divider phase and the same oscillator phase. Separate enables gate the code function as a whole, the transmit side and the receive side.

Top module: `pn_sync_engine`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `sync_out`, `sync_pulse`, `div_phase` and `nco_phase` are all 0.
- R2: The code comes from a 4-bit generator state S seeded with 4'b1000. Each chip is S[3], and the next state is {S[2:0], S[3]^S[2]} (polynomial x^4+x^3+1). The code repeats every 15 chips. With `master_sel`, `pn_en` and `sync_out_en` high, the generator advances on every edge and `sync_out` is registered from the chip of that edge. After reset, the first edge therefore puts chip 0 (a 1) on `sync_out`.
- R3: When `sync_out_en` is 0 at an edge, `sync_out` is 0 after that edge.
- R4: When `master_sel` is 0 (slave), `sync_out` stays 0.
- R5: The correlator samples `sync_in` on every edge where `pn_en` and `sync_in_en` are high. If the 15 most recent samples equal the code in transmit order, `sync_pulse` is high after the second edge that follows the edge that sampled the last chip.
- R6: `sync_pulse` is high for exactly one cycle per recognised code. A code that repeats back to back gives pulses exactly 15 cycles apart.
- R7: A received code with any chip inverted produces no pulse.
- R8: When `sync_in_en` or `pn_en` is 0, no pulse is produced, even while a valid code is being received.
- R9: `div_phase` counts from 0 to DIV_RATIO-1 and wraps. `nco_phase` adds PHASE_STEP every cycle. On the edge where `sync_pulse` is high, `div_phase` loads DIV_LOAD and `nco_phase` clears to 0.
- R10: A master whose `sync_out` is looped back to its own `sync_in` sees its first pulse 18 cycles after reset is released, then one pulse every 15 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1 = master (generates the code), 0 = slave |
| pn_en | input | 1 | Enables the pseudo-noise sync function |
| sync_out_en | input | 1 | Enables driving of `sync_out` |
| sync_in_en | input | 1 | Enables the receive correlator |
| sync_in | input | 1 | Serial sync stream received |
| sync_out | output | 1 | Serial sync stream transmitted |
| sync_pulse | output | 1 | One-cycle pulse on a recognised code |
| div_phase | output | DIV_W | Aligned clock-divider phase |
| nco_phase | output | PHASE_W | Aligned oscillator phase accumulator |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- the transmit line is quiet when disabled or in slave mode;
- a pulse is never two cycles wide;
- no pulse appears while receiving is disabled;
- the divider and accumulator either step normally or load on a pulse.

Only the bench scenarios can show the rest: the exact chip order of the generated code, the two-cycle pulse latency after the last chip, the rejection of a corrupted code, the 15-cycle pulse spacing, and the loopback timing of a master.

// File: rtl/pn_sync_pkg.sv
package pn_sync_pkg;
  localparam int unsigned GEN_W    = 4;
  localparam int unsigned CODE_LEN = (1 << GEN_W) - 1;
  localparam logic [GEN_W-1:0] GEN_SEED = 4'b1000;
  localparam logic [GEN_W-1:0] GEN_TAPS = 4'b1100;

  function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
    return {s[GEN_W-2:0], ^(s & GEN_TAPS)};
  endfunction

  // Expected code, first transmitted chip in the top bit.
  function automatic logic [CODE_LEN-1:0] gen_code();
    logic [GEN_W-1:0]    s;
    logic [CODE_LEN-1:0] c;
    s = GEN_SEED;
    c = '0;
    for (int i = 0; i < CODE_LEN; i++) begin
      c[CODE_LEN-1-i] = s[GEN_W-1];
      s = gen_step(s);
    end
    return c;
  endfunction
endpackage

// File: rtl/pn_code_gen.sv
module pn_code_gen
  import pn_sync_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic drive_en,
  output logic chip_out
);
  logic [GEN_W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= GEN_SEED;
      chip_out <= 1'b0;
    end else if (run) begin
      state    <= gen_step(state);
      chip_out <= drive_en & state[GEN_W-1];
    end else begin
      state    <= GEN_SEED;
      chip_out <= 1'b0;
    end
  end
endmodule

// File: rtl/pn_correlator.sv
module pn_correlator
  import pn_sync_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rx_on,
  input  logic chip_in,
  output logic hit
);
  localparam logic [CODE_LEN-1:0] EXPECT = gen_code();

  logic [CODE_LEN-1:0] window;
  logic                match_q;

  always_ff @(posedge clk) begin
    if (rst || !rx_on) begin
      window  <= '0;
      match_q <= 1'b0;
      hit     <= 1'b0;
    end else begin
      window  <= {window[CODE_LEN-2:0], chip_in};
      match_q <= (window == EXPECT);
      hit     <= match_q;
    end
  end
endmodule

// File: rtl/sync_phase_align.sv
module sync_phase_align #(
  parameter int unsigned DIV_RATIO  = 8,
  parameter int unsigned DIV_LOAD   = 0,
  parameter int unsigned PHASE_W    = 32,
  parameter logic [PHASE_W-1:0] PHASE_STEP = 32'h0123_4567,
  localparam int unsigned DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               align,
  output logic [DIV_W-1:0]   div_cnt,
  output logic [PHASE_W-1:0] phase_acc
);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_RATIO - 1);
  localparam logic [DIV_W-1:0] LOAD = DIV_W'(DIV_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      phase_acc <= '0;
    end else if (align) begin
      div_cnt   <= LOAD;
      phase_acc <= '0;
    end else begin
      div_cnt   <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
      phase_acc <= phase_acc + PHASE_STEP;
    end
  end
endmodule

// File: rtl/pn_sync_engine.sv
module pn_sync_engine #(
  parameter int unsigned DIV_RATIO  = 8,
  parameter int unsigned DIV_LOAD   = 0,
  parameter int unsigned PHASE_W    = 32,
  parameter logic [PHASE_W-1:0] PHASE_STEP = 32'h0123_4567,
  localparam int unsigned DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               master_sel,
  input  logic               pn_en,
  input  logic               sync_out_en,
  input  logic               sync_in_en,
  input  logic               sync_in,
  output logic               sync_out,
  output logic               sync_pulse,
  output logic [DIV_W-1:0]   div_phase,
  output logic [PHASE_W-1:0] nco_phase
);
  logic gen_run;
  logic rx_on;

  assign gen_run = master_sel & pn_en;
  assign rx_on   = pn_en & sync_in_en;

  pn_code_gen u_gen (
    .clk      (clk),
    .rst      (rst),
    .run      (gen_run),
    .drive_en (sync_out_en),
    .chip_out (sync_out)
  );

  pn_correlator u_corr (
    .clk     (clk),
    .rst     (rst),
    .rx_on   (rx_on),
    .chip_in (sync_in),
    .hit     (sync_pulse)
  );

  sync_phase_align #(
    .DIV_RATIO  (DIV_RATIO),
    .DIV_LOAD   (DIV_LOAD),
    .PHASE_W    (PHASE_W),
    .PHASE_STEP (PHASE_STEP)
  ) u_align (
    .clk       (clk),
    .rst       (rst),
    .align     (sync_pulse),
    .div_cnt   (div_phase),
    .phase_acc (nco_phase)
  );
endmodule

// File: rtl/pn_sync_chk.sv
module pn_sync_chk #(
  parameter int unsigned DIV_RATIO  = 8,
  parameter int unsigned DIV_LOAD   = 0,
  parameter int unsigned PHASE_W    = 32,
  parameter logic [PHASE_W-1:0] PHASE_STEP = 32'h0123_4567,
  localparam int unsigned DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               master_sel,
  input logic               pn_en,
  input logic               sync_out_en,
  input logic               sync_in_en,
  input logic               sync_out,
  input logic               sync_pulse,
  input logic [DIV_W-1:0]   div_phase,
  input logic [PHASE_W-1:0] nco_phase
);
  p_out_gated_r3: assert property (@(posedge clk) disable iff (rst)
    !sync_out_en |=> !sync_out);

  p_slave_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !master_sel |=> !sync_out);

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse);

  p_rx_off_r8: assert property (@(posedge clk) disable iff (rst)
    !(sync_in_en && pn_en) |=> !sync_pulse);

  p_align_load_r9: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> (div_phase == DIV_W'(DIV_LOAD)) && (nco_phase == '0));

  p_div_step_r9: assert property (@(posedge clk) disable iff (rst)
    !sync_pulse |=> div_phase == (($past(div_phase) == DIV_W'(DIV_RATIO - 1))
                                  ? '0 : $past(div_phase) + 1'b1));

  p_nco_step_r9: assert property (@(posedge clk) disable iff (rst)
    !sync_pulse |=> nco_phase == $past(nco_phase) + PHASE_STEP);
endmodule

bind pn_sync_engine pn_sync_chk #(
  .DIV_RATIO  (DIV_RATIO),
  .DIV_LOAD   (DIV_LOAD),
  .PHASE_W    (PHASE_W),
  .PHASE_STEP (PHASE_STEP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .master_sel  (master_sel),
  .pn_en       (pn_en),
  .sync_out_en (sync_out_en),
  .sync_in_en  (sync_in_en),
  .sync_out    (sync_out),
  .sync_pulse  (sync_pulse),
  .div_phase   (div_phase),
  .nco_phase   (nco_phase)
);

// File: tb/tb_pn_sync_engine.sv
module tb_pn_sync_engine;
  localparam int unsigned DIV_RATIO  = 8;
  localparam int unsigned DIV_LOAD   = 3;
  localparam logic [31:0] STEP       = 32'h0123_4567;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_sel = 1'b0, pn_en = 1'b0, sync_out_en = 1'b0, sync_in_en = 1'b0;
  logic tb_in = 1'b0, loop_sel = 1'b0;
  logic sync_in, sync_out, sync_pulse;
  logic [2:0]  div_phase;
  logic [31:0] nco_phase;
  logic [14:0] code;
  int checks = 0, errors = 0;

  assign sync_in = loop_sel ? sync_out : tb_in;

  always #5 clk = ~clk;

  pn_sync_engine #(.DIV_RATIO(DIV_RATIO), .DIV_LOAD(DIV_LOAD), .PHASE_STEP(STEP)) dut (
    .clk(clk), .rst(rst), .master_sel(master_sel), .pn_en(pn_en),
    .sync_out_en(sync_out_en), .sync_in_en(sync_in_en), .sync_in(sync_in),
    .sync_out(sync_out), .sync_pulse(sync_pulse), .div_phase(div_phase),
    .nco_phase(nco_phase));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Holds reset, then releases it at a negedge; inputs are set beforehand.
  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    master_sel = 1; pn_en = 1; sync_out_en = 1; sync_in_en = 1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 during reset", {sync_out, sync_pulse, div_phase, nco_phase != 0}, 0);
    rst = 1'b0;
    check("R1 after release", {sync_out, sync_pulse, div_phase, nco_phase != 0}, 0);
  endtask

  task automatic t_master_stream();
    master_sel = 1; pn_en = 1; sync_out_en = 1; sync_in_en = 0; loop_sel = 0;
    do_reset();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R2 chip", 32'(sync_out), 32'(code[14 - (i % 15)]));
    end
  endtask

  task automatic t_out_disabled();
    master_sel = 1; pn_en = 1; sync_out_en = 0;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R3 output disabled", 32'(sync_out), 0);
    end
  endtask

  task automatic t_slave_quiet();
    master_sel = 0; pn_en = 1; sync_out_en = 1;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R4 slave quiet", 32'(sync_out), 0);
    end
  endtask

  // Feeds reps copies of pattern (first chip in bit 14), then zeros.
  // Returns the negedge indices of the first two pulses and the pulse count.
  task automatic stream(input logic [14:0] pat, input int reps,
                        output int p1, output int p2, output int cnt);
    p1 = -1; p2 = -1; cnt = 0;
    for (int i = 0; i < 15 * reps + 10; i++) begin
      if (i > 0 && sync_pulse) begin
        if (cnt == 0) p1 = i; else if (cnt == 1) p2 = i;
        cnt++;
      end
      tb_in = (i < 15 * reps) ? pat[14 - (i % 15)] : 1'b0;
      @(negedge clk);
    end
    tb_in = 1'b0;
  endtask

  task automatic t_correlate();
    int p1, p2, cnt;
    master_sel = 0; pn_en = 1; sync_in_en = 1; loop_sel = 0; tb_in = 0;
    do_reset();
    // Last chip is set at index 14 and sampled just after it: pulse visible at index 17.
    for (int i = 0; i < 15; i++) begin
      tb_in = code[14 - i];
      @(negedge clk);
    end
    tb_in = 0;
    check("R5 pulse low after +0", 32'(sync_pulse), 0);
    @(negedge clk);
    check("R5 pulse low after +1", 32'(sync_pulse), 0);
    @(negedge clk);
    check("R5 pulse after +2", 32'(sync_pulse), 1);
    @(negedge clk);
    check("R6 pulse one wide", 32'(sync_pulse), 0);
    check("R9 divider loaded", 32'(div_phase), DIV_LOAD);
    check("R9 phase cleared", nco_phase, 0);
    @(negedge clk);
    check("R9 divider steps", 32'(div_phase), (DIV_LOAD + 1) % DIV_RATIO);
    check("R9 phase steps", nco_phase, STEP);
    do_reset();
    stream(code, 2, p1, p2, cnt);
    check("R6 first pulse index", p1, 17);
    check("R6 second pulse index", p2, 32);
    check("R6 pulse count", cnt, 2);
  endtask

  task automatic t_corrupt();
    int p1, p2, cnt;
    master_sel = 0; pn_en = 1; sync_in_en = 1;
    for (int b = 0; b < 15; b += 7) begin
      do_reset();
      stream(code ^ (15'd1 << b), 1, p1, p2, cnt);
      check("R7 corrupted code", cnt, 0);
    end
  endtask

  task automatic t_rx_disabled();
    int p1, p2, cnt;
    master_sel = 0; pn_en = 1; sync_in_en = 0;
    do_reset();
    stream(code, 2, p1, p2, cnt);
    check("R8 input disabled", cnt, 0);
    pn_en = 0; sync_in_en = 1;
    do_reset();
    stream(code, 2, p1, p2, cnt);
    check("R8 pn disabled", cnt, 0);
  endtask

  task automatic t_loopback();
    int seen = 0;
    int first = -1;
    int last = -1;
    int bad = 0;
    master_sel = 1; pn_en = 1; sync_out_en = 1; sync_in_en = 1; loop_sel = 1;
    do_reset();
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (sync_pulse) begin
        if (seen == 0) first = i;
        else if (i - last != 15) bad++;
        last = i;
        seen++;
      end
    end
    check("R10 first loopback pulse", first, 18);
    check("R10 pulse spacing errors", bad, 0);
    check("R10 pulse count", seen, 3);
    loop_sel = 0;
  endtask

  initial begin
    code = '0;
    begin
      logic [3:0] s;
      s = 4'b1000;
      for (int i = 0; i < 15; i++) begin
        code[14 - i] = s[3];
        s = {s[2:0], s[3] ^ s[2]};
      end
    end
    t_reset();
    t_master_stream();
    t_out_disabled();
    t_slave_quiet();
    t_correlate();
    t_corrupt();
    t_rx_disabled();
    t_loopback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule